// File: doc/BRIEF.md
# PLL Clock Frequency Calculator

This block turns three control register images (a clock-source control word, a post-divider word and a PLL settings word) into clock frequencies in hertz. It works out the PLL reference frequency, the core clock, the high-speed bus clock and the peripheral bus clock. The core clock comes either straight from the reference or from a fractional-N PLL whose 10-bit numerator is signed.

A one-cycle `start` pulse takes a snapshot of the register inputs. One shared restoring divider then performs three divisions in turn: the PLL ratio, the high-speed post-divide and the peripheral post-divide. It produces one quotient bit per cycle, so no wide divider is needed in a single cycle. The four results are held until the next calculation finishes. A clock-select input reads out any one of them, or the fixed low-frequency clock.

A `start` that arrives while a calculation is running is remembered. As soon as the current run ends, a fresh run begins from the register values present at that moment.

Top module: `ccmFreqCalc`

## Requirements
- R1: The reference frequency is 33554432 Hz (32768 × 1024) when control bits [2:1] equal binary 01. For any other value of those bits it is 26000000 Hz.
- R2: The core clock equals the reference when control bit 7 is 1 or control bit 3 is 0. In every other case it equals the PLL output.
- R3: The PLL word is decoded as follows. Bits [9:0] are a two's-complement numerator. Bits [13:10] are the integer factor, and any value below 5 is used as 5. Bits [25:16] plus one are the denominator. Bits [29:26] plus one are the pre-divide. All other bits of all three register images are ignored.
- R4: The PLL output is computed with truncating division as ((2 × (reference >> 10) × (integer × denominator + numerator)) / (denominator × pre-divide)) << 10, keeping only the low 32 bits. A negative bracketed sum counts as 0.
- R5: The high-speed clock is the core clock divided by (1 + post-divider bits [13:11]), with truncation.
- R6: The peripheral clock is the high-speed clock divided by (1 + post-divider bits [7:6]), with truncation.
- R7: `selFreq` depends on `clkSel`: 0 gives 0, 1 gives the core clock, 2 gives the high-speed clock, 3 gives the peripheral clock, 4 gives 32768, and 5 to 7 give 0.
- R8: A `start` sampled while idle raises `busy` at that edge. When a calculation completes, `done` is high for exactly one cycle. On that same edge `busy` falls, unless a rerun begins.
- R9: After reset all four frequency outputs are 0. They keep their values until a calculation completes, and then all four change together on the edge that raises `done`.
- R10: A `start` that arrives while busy, including one on the completing edge, causes a new run to begin immediately after completion. The new run uses the register values present on that completing edge.
- R11: The register inputs are captured when a run begins. Changing them during the run does not affect that run's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a calculation |
| ctrlReg | input | 32 | Clock-source control word |
| div0Reg | input | 32 | Post-divider word |
| pllReg | input | 32 | PLL settings word |
| clkSel | input | 3 | Frequency read-out select |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| refFreq | output | 32 | Latched reference frequency |
| coreFreq | output | 32 | Latched core clock |
| hsFreq | output | 32 | Latched high-speed clock |
| perFreq | output | 32 | Latched peripheral clock |
| selFreq | output | 32 | Selected frequency |

## Verification
The interesting collision is a new `start` arriving on the very edge where a calculation commits its results and raises `done`. To provoke it, the bench first measures the length of a full run. It then times a second `start` so that it lands on the completing edge of a later run, with different register values applied. The bench judges the outcome on three points. `done` and `busy` must both be high in that cycle, which shows the rerun has begun. The committed values must still be those of the old run. The following completion must deliver the values of the new registers.

// File: rtl/ccmFreqPkg.sv
package ccmFreqPkg;

  typedef enum logic [1:0] {
    OP_PLL = 2'd0,
    OP_HS  = 2'd1,
    OP_PER = 2'd2
  } divOp_e;

  typedef struct packed {
    logic   snap;
    logic   launch;
    divOp_e op;
    logic   capPll;
    logic   capHs;
    logic   commit;
  } calcStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CORE = 3'd1,
    SEL_HS   = 3'd2,
    SEL_PER  = 3'd3,
    SEL_LOW  = 3'd4
  } clkSel_e;

  // field positions decoded from the register images
  localparam int REFSEL_LSB = 1;
  localparam int PLLEN_BIT  = 3;
  localparam int BYPASS_BIT = 7;
  localparam int MFN_LSB    = 0;
  localparam int MFN_W      = 10;
  localparam int MFI_LSB    = 10;
  localparam int MFI_W      = 4;
  localparam int MFD_LSB    = 16;
  localparam int MFD_W      = 10;
  localparam int PD_LSB     = 26;
  localparam int PD_W       = 4;
  localparam int HSDIV_LSB  = 11;
  localparam int HSDIV_W    = 3;
  localparam int PERDIV_LSB = 6;
  localparam int PERDIV_W   = 2;

endpackage

// File: rtl/ccmSeqDivider.sv
module ccmSeqDivider #(
  parameter int DIVIDEND_W = 64,
  parameter int DIVISOR_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [DIVIDEND_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]  divisor,
  output logic [DIVIDEND_W-1:0] quotient,
  output logic                  doneP
);

  localparam int CNT_W = $clog2(DIVIDEND_W + 1);

  logic [DIVIDEND_W-1:0] quoQ;
  logic [DIVISOR_W-1:0]  remQ;
  logic [DIVISOR_W-1:0]  dsrQ;
  logic [CNT_W-1:0]      cntQ;
  logic                  runQ;
  logic                  doneQ;

  logic [DIVISOR_W:0] trial;
  logic [DIVISOR_W:0] diff;
  logic               fits;
  logic               unusedDiffTop;

  always_comb begin
    trial = {remQ, quoQ[DIVIDEND_W-1]};
    fits  = (trial >= {1'b0, dsrQ});
    diff  = trial - {1'b0, dsrQ};
  end

  assign unusedDiffTop = diff[DIVISOR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoQ  <= '0;
      remQ  <= '0;
      dsrQ  <= '0;
      cntQ  <= '0;
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else if (load) begin
      quoQ  <= dividend;
      remQ  <= '0;
      dsrQ  <= divisor;
      cntQ  <= CNT_W'(DIVIDEND_W);
      runQ  <= 1'b1;
      doneQ <= 1'b0;
    end else if (runQ) begin
      remQ <= fits ? diff[DIVISOR_W-1:0] : trial[DIVISOR_W-1:0];
      quoQ <= {quoQ[DIVIDEND_W-2:0], fits};
      cntQ <= cntQ - CNT_W'(1);
      if (cntQ == CNT_W'(1)) begin
        runQ  <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        doneQ <= 1'b0;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign quotient = quoQ;
  assign doneP    = doneQ;

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (remQ < dsrQ)) else $error("partial remainder out of range"); // R4

  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ) else $error("divider done longer than a cycle"); // R8

endmodule

// File: rtl/ccmCalcCtrl.sv
module ccmCalcCtrl
  import ccmFreqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divDone,
  output calcStrobe_t strb,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_PLL,
    ST_WAIT_PLL,
    ST_LOAD_HS,
    ST_WAIT_HS,
    ST_LOAD_PER,
    ST_WAIT_PER
  } calcState_e;

  calcState_e stateQ, stateD;
  logic       pendingQ;
  logic       doneQ;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.snap = 1'b1;
          stateD    = ST_LOAD_PLL;
        end
      end
      ST_LOAD_PLL: begin
        strb.launch = 1'b1;
        strb.op     = OP_PLL;
        stateD      = ST_WAIT_PLL;
      end
      ST_WAIT_PLL: begin
        if (divDone) begin
          strb.capPll = 1'b1;
          stateD      = ST_LOAD_HS;
        end
      end
      ST_LOAD_HS: begin
        strb.launch = 1'b1;
        strb.op     = OP_HS;
        stateD      = ST_WAIT_HS;
      end
      ST_WAIT_HS: begin
        if (divDone) begin
          strb.capHs = 1'b1;
          stateD     = ST_LOAD_PER;
        end
      end
      ST_LOAD_PER: begin
        strb.launch = 1'b1;
        strb.op     = OP_PER;
        stateD      = ST_WAIT_PER;
      end
      ST_WAIT_PER: begin
        strb.op = OP_PER;
        if (divDone) begin
          strb.commit = 1'b1;
          if (pendingQ || start) begin
            strb.snap = 1'b1;
            stateD    = ST_LOAD_PLL;
          end else begin
            stateD = ST_IDLE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.commit;
      if (strb.snap) begin
        pendingQ <= 1'b0;
      end else if (start && stateQ != ST_IDLE) begin
        pendingQ <= 1'b1;
      end
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy) else $error("start while idle did not raise busy"); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held for more than one cycle"); // R8

  AST_PENDING_RERUNS: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && strb.commit) |=> (busy && done)) else $error("pending start lost"); // R10

endmodule

// File: rtl/ccmDatapath.sv
module ccmDatapath
  import ccmFreqPkg::*;
#(
  parameter int REG_W      = 32,
  parameter int FREQ_W     = 32,
  parameter int DIVIDEND_W = 64,
  parameter int FRAC_SHIFT = 10,
  parameter int HI_REF_HZ  = 26000000,
  parameter int LO_HZ      = 32768,
  parameter int REF_SCALE  = 1024,
  parameter int MFI_MIN    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  calcStrobe_t           strb,
  input  logic [REG_W-1:0]      ctrlReg,
  input  logic [REG_W-1:0]      div0Reg,
  input  logic [REG_W-1:0]      pllReg,
  input  logic [DIVIDEND_W-1:0] divQuot,
  output logic [DIVIDEND_W-1:0] divDividend,
  output logic [FREQ_W-1:0]     divDivisor,
  output logic [FREQ_W-1:0]     refOut,
  output logic [FREQ_W-1:0]     coreOut,
  output logic [FREQ_W-1:0]     hsOut,
  output logic [FREQ_W-1:0]     perOut
);

  localparam logic [FREQ_W-1:0] LO_REF_VAL = FREQ_W'(LO_HZ * REF_SCALE);
  localparam logic [FREQ_W-1:0] HI_REF_VAL = FREQ_W'(HI_REF_HZ);

  // snapshot of the decoded fields
  logic                refLowQ;
  logic                usePllQ;
  logic [PD_W-1:0]     pdQ;
  logic [MFD_W-1:0]    mfdQ;
  logic [MFI_W-1:0]    mfiQ;
  logic [MFN_W-1:0]    mfnQ;
  logic [HSDIV_W-1:0]  hsDivQ;
  logic [PERDIV_W-1:0] perDivQ;

  // intermediate results
  logic [FREQ_W-1:0] coreQ;
  logic [FREQ_W-1:0] hsQ;

  // latched outputs
  logic [FREQ_W-1:0] refOutQ;
  logic [FREQ_W-1:0] coreOutQ;
  logic [FREQ_W-1:0] hsOutQ;
  logic [FREQ_W-1:0] perOutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refLowQ <= 1'b0;
      usePllQ <= 1'b0;
      pdQ     <= '0;
      mfdQ    <= '0;
      mfiQ    <= '0;
      mfnQ    <= '0;
      hsDivQ  <= '0;
      perDivQ <= '0;
    end else if (strb.snap) begin
      refLowQ <= (ctrlReg[REFSEL_LSB+1:REFSEL_LSB] == 2'b01);
      usePllQ <= ctrlReg[PLLEN_BIT] & ~ctrlReg[BYPASS_BIT];
      pdQ     <= pllReg[PD_LSB+PD_W-1:PD_LSB];
      mfdQ    <= pllReg[MFD_LSB+MFD_W-1:MFD_LSB];
      mfiQ    <= pllReg[MFI_LSB+MFI_W-1:MFI_LSB];
      mfnQ    <= pllReg[MFN_LSB+MFN_W-1:MFN_LSB];
      hsDivQ  <= div0Reg[HSDIV_LSB+HSDIV_W-1:HSDIV_LSB];
      perDivQ <= div0Reg[PERDIV_LSB+PERDIV_W-1:PERDIV_LSB];
    end
  end

  logic unusedRegBits;
  assign unusedRegBits = ^{ctrlReg[REG_W-1:BYPASS_BIT+1], ctrlReg[BYPASS_BIT-1:PLLEN_BIT+1],
                           ctrlReg[REFSEL_LSB-1:0],
                           div0Reg[REG_W-1:HSDIV_LSB+HSDIV_W],
                           div0Reg[HSDIV_LSB-1:PERDIV_LSB+PERDIV_W],
                           div0Reg[PERDIV_LSB-1:0],
                           pllReg[REG_W-1:PD_LSB+PD_W],
                           pllReg[MFD_LSB-1:MFI_LSB+MFI_W]};

  // PLL ratio operands
  logic [FREQ_W-1:0]     refHz;
  logic [FREQ_W-1:0]     baseHz;
  logic [MFI_W-1:0]      mfiEff;
  logic [FREQ_W-1:0]     mfdP1;
  logic [FREQ_W-1:0]     pdP1;
  logic [FREQ_W-1:0]     sumRaw;
  logic [FREQ_W-1:0]     sumPos;
  logic [DIVIDEND_W-1:0] pllProd;
  logic [FREQ_W-1:0]     pllDivisor;
  logic [FREQ_W-1:0]     coreSel;

  always_comb begin
    refHz      = refLowQ ? LO_REF_VAL : HI_REF_VAL;
    baseHz     = refHz >> FRAC_SHIFT;
    mfiEff     = (mfiQ < MFI_W'(MFI_MIN)) ? MFI_W'(MFI_MIN) : mfiQ;
    mfdP1      = FREQ_W'(mfdQ) + FREQ_W'(1);
    pdP1       = FREQ_W'(pdQ) + FREQ_W'(1);
    sumRaw     = FREQ_W'(mfiEff) * mfdP1
               + {{(FREQ_W-MFN_W){mfnQ[MFN_W-1]}}, mfnQ};
    sumPos     = sumRaw[FREQ_W-1] ? '0 : sumRaw;
    pllProd    = DIVIDEND_W'(2) * DIVIDEND_W'(baseHz) * DIVIDEND_W'(sumPos);
    pllDivisor = mfdP1 * pdP1;
    coreSel    = usePllQ ? FREQ_W'(divQuot << FRAC_SHIFT) : refHz;
  end

  always_comb begin
    case (strb.op)
      OP_PLL: begin
        divDividend = pllProd;
        divDivisor  = pllDivisor;
      end
      OP_HS: begin
        divDividend = DIVIDEND_W'(coreQ);
        divDivisor  = FREQ_W'(hsDivQ) + FREQ_W'(1);
      end
      default: begin
        divDividend = DIVIDEND_W'(hsQ);
        divDivisor  = FREQ_W'(perDivQ) + FREQ_W'(1);
      end
    endcase
  end

  logic unusedQuot;
  assign unusedQuot = ^divQuot[DIVIDEND_W-1:FREQ_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreQ    <= '0;
      hsQ      <= '0;
      refOutQ  <= '0;
      coreOutQ <= '0;
      hsOutQ   <= '0;
      perOutQ  <= '0;
    end else begin
      if (strb.capPll) coreQ <= coreSel;
      if (strb.capHs)  hsQ   <= divQuot[FREQ_W-1:0];
      if (strb.commit) begin
        refOutQ  <= refHz;
        coreOutQ <= coreQ;
        hsOutQ   <= hsQ;
        perOutQ  <= divQuot[FREQ_W-1:0];
      end
    end
  end

  assign refOut  = refOutQ;
  assign coreOut = coreOutQ;
  assign hsOut   = hsOutQ;
  assign perOut  = perOutQ;

  AST_OUTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable({refOutQ, coreOutQ, hsOutQ, perOutQ}))
    else $error("outputs moved without a commit"); // R9

  AST_HS_NOT_ABOVE_CORE: assert property (@(posedge clk) disable iff (!rstN)
    hsOutQ <= coreOutQ) else $error("high-speed clock above core"); // R5

  AST_PER_NOT_ABOVE_HS: assert property (@(posedge clk) disable iff (!rstN)
    perOutQ <= hsOutQ) else $error("peripheral clock above high-speed"); // R6

  AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |-> (divDivisor != '0)) else $error("zero divisor launched"); // R3

endmodule

// File: rtl/ccmFreqCalc.sv
module ccmFreqCalc
  import ccmFreqPkg::*;
#(
  parameter int REG_W      = 32,
  parameter int FREQ_W     = 32,
  parameter int DIVIDEND_W = 64,
  parameter int FRAC_SHIFT = 10,
  parameter int HI_REF_HZ  = 26000000,
  parameter int LO_HZ      = 32768,
  parameter int REF_SCALE  = 1024,
  parameter int MFI_MIN    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [REG_W-1:0]  ctrlReg,
  input  logic [REG_W-1:0]  div0Reg,
  input  logic [REG_W-1:0]  pllReg,
  input  logic [2:0]        clkSel,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] refFreq,
  output logic [FREQ_W-1:0] coreFreq,
  output logic [FREQ_W-1:0] hsFreq,
  output logic [FREQ_W-1:0] perFreq,
  output logic [FREQ_W-1:0] selFreq
);

  calcStrobe_t           strb;
  logic                  divDone;
  logic [DIVIDEND_W-1:0] divQuot;
  logic [DIVIDEND_W-1:0] divDividend;
  logic [FREQ_W-1:0]     divDivisor;

  ccmCalcCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divDone (divDone),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  ccmDatapath #(
    .REG_W      (REG_W),
    .FREQ_W     (FREQ_W),
    .DIVIDEND_W (DIVIDEND_W),
    .FRAC_SHIFT (FRAC_SHIFT),
    .HI_REF_HZ  (HI_REF_HZ),
    .LO_HZ      (LO_HZ),
    .REF_SCALE  (REF_SCALE),
    .MFI_MIN    (MFI_MIN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ctrlReg     (ctrlReg),
    .div0Reg     (div0Reg),
    .pllReg      (pllReg),
    .divQuot     (divQuot),
    .divDividend (divDividend),
    .divDivisor  (divDivisor),
    .refOut      (refFreq),
    .coreOut     (coreFreq),
    .hsOut       (hsFreq),
    .perOut      (perFreq)
  );

  ccmSeqDivider #(
    .DIVIDEND_W (DIVIDEND_W),
    .DIVISOR_W  (FREQ_W)
  ) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strb.launch),
    .dividend (divDividend),
    .divisor  (divDivisor),
    .quotient (divQuot),
    .doneP    (divDone)
  );

  always_comb begin
    case (clkSel)
      SEL_CORE: selFreq = coreFreq;
      SEL_HS:   selFreq = hsFreq;
      SEL_PER:  selFreq = perFreq;
      SEL_LOW:  selFreq = FREQ_W'(LO_HZ);
      default:  selFreq = '0;
    endcase
  end

endmodule

// File: tb/sim_ccmFreqCalc.sv
module sim_ccmFreqCalc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrlReg = '0;
  logic [31:0] div0Reg = '0;
  logic [31:0] pllReg = '0;
  logic [2:0]  clkSel = '0;
  logic        busy, done;
  logic [31:0] refFreq, coreFreq, hsFreq, perFreq, selFreq;

  int nChecks = 0;
  int nErrors = 0;

  always #10 clk = ~clk;  // 50 MHz

  ccmFreqCalc u0 (
    .clk(clk), .rstN(rstN), .start(start), .ctrlReg(ctrlReg), .div0Reg(div0Reg),
    .pllReg(pllReg), .clkSel(clkSel), .busy(busy), .done(done), .refFreq(refFreq),
    .coreFreq(coreFreq), .hsFreq(hsFreq), .perFreq(perFreq), .selFreq(selFreq)
  );

  // {ctrl, div0, pll, expRef, expCore, expHs, expPer}
  localparam int NVEC = 7;
  localparam logic [223:0] VEC [NVEC] = '{
    // PLL on, integer 6, hs /2, per /2
    {32'h00000008, 32'h00000840, 32'h00001800, 32'd26000000, 32'd311992320, 32'd155996160, 32'd77998080},
    // PLL off, ignored bits all set
    {32'hFFFFFF71, 32'hFFFFC73F, 32'h00001800, 32'd26000000, 32'd26000000, 32'd26000000, 32'd26000000},
    // low reference, integer clamped 2->5, hs /8, per /4
    {32'h0000000A, 32'h000038C0, 32'h00000800, 32'd33554432, 32'd335544320, 32'd41943040, 32'd10485760},
    // bypass bit forces reference, hs /3, per /3
    {32'h00000088, 32'h00001080, 32'h00001800, 32'd26000000, 32'd26000000, 32'd8666666, 32'd2888888},
    // negative numerator -2, denominator 4, pre-divide 2
    {32'h00000008, 32'h00000000, 32'h04032BFE, 32'd26000000, 32'd246993920, 32'd246993920, 32'd246993920},
    // select bits 11 give high ref; result wraps to 32 bits
    {32'h0000000E, 32'h00000040, 32'h00013DFF, 32'd26000000, 32'd1180751872, 32'd1180751872, 32'd590375936},
    // sum 5-512 negative -> 0
    {32'h00000008, 32'h00000000, 32'h00000200, 32'd26000000, 32'd0, 32'd0, 32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  task automatic applyRegs(input int idx);
    ctrlReg = VEC[idx][223:192];
    div0Reg = VEC[idx][191:160];
    pllReg  = VEC[idx][159:128];
  endtask

  task automatic checkVec(input int idx, input string ctx);
    chk({"R1 ref ", ctx}, refFreq, VEC[idx][127:96]);
    chk({"R2/R3/R4 core ", ctx}, coreFreq, VEC[idx][95:64]);
    chk({"R5 hs ", ctx}, hsFreq, VEC[idx][63:32]);
    chk({"R6 per ", ctx}, perFreq, VEC[idx][31:0]);
  endtask

  task automatic waitDone(output int cycles);
    cycles = 0;
    while (!done) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL R8 watchdog expired");
    finishSim();
  end

  initial begin
    int runLen;
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset busy", 32'(busy), 32'd0);
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R9 reset ref", refFreq, 32'd0);
    chk("R9 reset core", coreFreq, 32'd0);
    chk("R9 reset hs", hsFreq, 32'd0);
    chk("R9 reset per", perFreq, 32'd0);
    clkSel = 3'd4; #1;
    chk("R7 low clock at reset", selFreq, 32'd32768);

    // vector walk
    runLen = 0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      applyRegs(i);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", 32'(busy), 32'd1);
      waitDone(cyc);
      if (i == 0) runLen = cyc + 1;
      chk("R8 busy falls with done", 32'(busy), 32'd0);
      checkVec(i, $sformatf("vec%0d", i));
      @(negedge clk);
      chk("R8 done single cycle", 32'(done), 32'd0);
    end

    // R7 select read-out using last vector, then vector 0 values
    @(negedge clk);
    applyRegs(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    for (int s = 0; s < 8; s++) begin
      logic [31:0] expSel;
      clkSel = 3'(s); #1;
      case (s)
        1: expSel = VEC[0][95:64];
        2: expSel = VEC[0][63:32];
        3: expSel = VEC[0][31:0];
        4: expSel = 32'd32768;
        default: expSel = 32'd0;
      endcase
      chk($sformatf("R7 select %0d", s), selFreq, expSel);
    end

    // R9 hold during run, R11 snapshot, R10 pending start
    @(negedge clk);
    applyRegs(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 core held during run", coreFreq, VEC[0][95:64]);
    chk("R9 per held during run", perFreq, VEC[0][31:0]);
    applyRegs(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    checkVec(2, "R11 snapshot");
    chk("R10 rerun keeps busy", 32'(busy), 32'd1);
    waitDone(cyc);
    @(negedge clk);
    waitDone(cyc);
    checkVec(3, "R10 pending rerun");
    chk("R10 idle after rerun", 32'(busy), 32'd0);

    // R10 start landing on the completing edge
    @(negedge clk);
    applyRegs(4);
    start = 1'b1;
    for (int k = 1; k < runLen; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (k == runLen - 1) begin
        applyRegs(5);
        start = 1'b1;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R10 done on coincident edge", 32'(done), 32'd1);
    chk("R10 busy on coincident edge", 32'(busy), 32'd1);
    checkVec(4, "R10 old run at coincident edge");
    @(negedge clk);
    waitDone(cyc);
    checkVec(5, "R10 coincident rerun");

    @(negedge clk);
    finishSim();
  end

endmodule